// File: doc/BRIEF.md
# Integer Operate Unit with Per-Instruction Trap Enable

This block is the 64-bit integer execute stage of a processor core. Each cycle it may accept one operation with these inputs: a first operand, a second operand taken either from a register or from an 8-bit zero-extended literal, a 4-bit operation code, a 3-bit condition selector, a trap-enable bit taken from the instruction, and the old contents of the destination register. One cycle later it presents the result, a destination write enable and an overflow trap flag.

It covers full-width and 32-bit add and subtract, scaled add and subtract by 4 or 8, four compares that yield 0 or 1, three bitwise logical operations and a conditional move. No mode register and no condition codes exist. Overflow trapping is a property of the single operation being issued. Traps are imprecise, so a raised trap flag never blocks the register write. The core's retire logic merges the trap flag with the traps of other operations.

Top module: `iop_unit`

## Requirements
- R1: An operation presented with `issue_i` high at a rising edge yields `res_vld_o` high for exactly the following cycle, and the result, write enable and trap flag belong to that operation. Back-to-back issues give back-to-back results.
- R2: When `use_lit_i` is 1, the second operand is `lit_i` zero-extended to 64 bits and `opb_i` has no effect. When `use_lit_i` is 0, the second operand is `opb_i`.
- R3: Op 0 gives A+B and op 1 gives A-B, both modulo 2^64.
- R4: For ops 0 and 1, a signed 64-bit overflow raises `ovf_o` only when `trap_en_i` was 1. With `trap_en_i` at 0 the same operation gives the same result with `ovf_o` low.
- R5: A trapping overflow still writes its wrapped result: `wr_en_o` is 1 together with `ovf_o`.
- R6: Op 2 (add) and op 3 (subtract) use only the low 32 bits of both operands. They return that 32-bit result sign-extended to 64 bits, and they judge overflow on the 32-bit signed result.
- R7: Scaled ops compute (A<<2)+B for op 4, (A<<3)+B for op 5, (A<<2)-B for op 6 and (A<<3)-B for op 7. They never raise `ovf_o`.
- R8: The compares write 1 when true and 0 when false. The tests are A==B (op 8), signed A<B (op 9), signed A<=B (op 10) and unsigned A<B (op 11).
- R9: Op 12 gives A AND B, op 13 gives A OR B and op 14 gives A XOR B.
- R10: Op 15 is a conditional move that tests A with `cond_i`. The codes are 0 A==0, 1 A!=0, 2 A<0, 3 A>=0, 4 A<=0, 5 A>0, 6 bit 0 set, 7 bit 0 clear. When the test holds, the result is B and `wr_en_o` is 1. Otherwise `wr_en_o` is 0 and the result equals `old_i`.
- R11: During and directly after reset, `res_o`, `res_vld_o`, `wr_en_o` and `ovf_o` are all 0.
- R12: In a cycle that follows no issue, `res_vld_o`, `wr_en_o` and `ovf_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue_i | input | 1 | Operation present this cycle |
| op_i | input | 4 | Operation code |
| cond_i | input | 3 | Conditional-move test selector |
| trap_en_i | input | 1 | Overflow trap enable of this operation |
| use_lit_i | input | 1 | Take second operand from literal |
| lit_i | input | 8 | Literal operand |
| opa_i | input | 64 | First operand |
| opb_i | input | 64 | Second register operand |
| old_i | input | 64 | Previous destination value |
| res_o | output | 64 | Registered result |
| res_vld_o | output | 1 | Result valid |
| wr_en_o | output | 1 | Destination write enable |
| ovf_o | output | 1 | Overflow trap flag |

## Verification
The output stage is the block's only state, so a fault there appears at the ports in the cycle right after the issue. A lost or doubled valid, or a write enable that stays set after a failed conditional move, shows up at once. A stale or mis-selected result shows up as a wrong value on the next result. Trap-flag faults are found by issuing each overflow case twice, once with trap enable set and once with it clear. Pairs of operations with identical register operands but opposite literal selection find a wrong second-operand choice.

// File: rtl/iop_pkg.sv
package iop_pkg;
   typedef enum logic [3:0] {
      OP_ADD_D  = 4'd0,
      OP_SUB_D  = 4'd1,
      OP_ADD_W  = 4'd2,
      OP_SUB_W  = 4'd3,
      OP_SADD4  = 4'd4,
      OP_SADD8  = 4'd5,
      OP_SSUB4  = 4'd6,
      OP_SSUB8  = 4'd7,
      OP_CEQ    = 4'd8,
      OP_CLT    = 4'd9,
      OP_CLE    = 4'd10,
      OP_CULT   = 4'd11,
      OP_AND    = 4'd12,
      OP_OR     = 4'd13,
      OP_XOR    = 4'd14,
      OP_CMOV   = 4'd15
   } iop_op_e;

   typedef enum logic [2:0] {
      CC_ZERO  = 3'd0,
      CC_NZERO = 3'd1,
      CC_NEG   = 3'd2,
      CC_NNEG  = 3'd3,
      CC_NPOS  = 3'd4,
      CC_POS   = 3'd5,
      CC_ODD   = 3'd6,
      CC_EVEN  = 3'd7
   } iop_cc_e;
endpackage

// File: rtl/iop_arith.sv
module iop_arith
   import iop_pkg::*;
#(
   parameter int DATA_W      = 64,
   parameter int WORD_W      = 32,
   parameter int SHIFT_SMALL = 2,
   parameter int SHIFT_LARGE = 3,
   parameter bit WORD_OPS    = 1'b1
) (
   input  iop_op_e             op,
   input  logic [DATA_W-1:0]   a,
   input  logic [DATA_W-1:0]   b,
   output logic [DATA_W-1:0]   y,
   output logic                ovf
);
   localparam int MSB  = DATA_W - 1;
   localparam int WMSB = WORD_W - 1;
   localparam int EXT  = DATA_W - WORD_W;

   logic              is_sub;
   logic [MSB:0]      a_sc;
   logic [MSB:0]      b_eff;
   logic [MSB:0]      full;
   logic              ovf_d;
   logic              ovf_w;
   logic [MSB:0]      word_res;

   always_comb begin
      is_sub = (op == OP_SUB_D) || (op == OP_SUB_W) ||
               (op == OP_SSUB4) || (op == OP_SSUB8);
      unique case (op)
         OP_SADD4, OP_SSUB4: a_sc = a << SHIFT_SMALL;
         OP_SADD8, OP_SSUB8: a_sc = a << SHIFT_LARGE;
         default:            a_sc = a;
      endcase
      b_eff = is_sub ? ~b : b;
      full  = a_sc + b_eff + {{(DATA_W-1){1'b0}}, is_sub};
      ovf_d = (a_sc[MSB] == b_eff[MSB]) && (full[MSB] != a_sc[MSB]);
      ovf_w = (a_sc[WMSB] == b_eff[WMSB]) && (full[WMSB] != a_sc[WMSB]);
   end

   generate
      if (WORD_OPS) begin : g_word
         assign word_res = {{EXT{full[WMSB]}}, full[WMSB:0]};
      end else begin : g_noword
         assign word_res = full;
      end
   endgenerate

   always_comb begin
      y   = full;
      ovf = 1'b0;
      unique case (op)
         OP_ADD_D, OP_SUB_D: ovf = ovf_d;
         OP_ADD_W, OP_SUB_W: begin
            y   = word_res;
            ovf = WORD_OPS ? ovf_w : ovf_d;
         end
         default: ovf = 1'b0;
      endcase
   end
endmodule

// File: rtl/iop_cmp.sv
module iop_cmp
   import iop_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  iop_op_e             op,
   input  iop_cc_e             cc,
   input  logic [DATA_W-1:0]   a,
   input  logic [DATA_W-1:0]   b,
   output logic                cmp_true,
   output logic                cc_ok
);
   localparam int MSB = DATA_W - 1;

   logic eq, slt, ult, a_zero;

   always_comb begin
      eq     = (a == b);
      slt    = $signed(a) < $signed(b);
      ult    = a < b;
      a_zero = (a == '0);
      unique case (op)
         OP_CEQ:  cmp_true = eq;
         OP_CLT:  cmp_true = slt;
         OP_CLE:  cmp_true = slt | eq;
         OP_CULT: cmp_true = ult;
         default: cmp_true = 1'b0;
      endcase
      unique case (cc)
         CC_ZERO:  cc_ok = a_zero;
         CC_NZERO: cc_ok = !a_zero;
         CC_NEG:   cc_ok = a[MSB];
         CC_NNEG:  cc_ok = !a[MSB];
         CC_NPOS:  cc_ok = a[MSB] | a_zero;
         CC_POS:   cc_ok = !a[MSB] && !a_zero;
         CC_ODD:   cc_ok = a[0];
         default:  cc_ok = !a[0];
      endcase
   end
endmodule

// File: rtl/iop_logic.sv
module iop_logic
   import iop_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  iop_op_e             op,
   input  logic [DATA_W-1:0]   a,
   input  logic [DATA_W-1:0]   b,
   output logic [DATA_W-1:0]   y
);
   always_comb begin
      unique case (op)
         OP_AND:  y = a & b;
         OP_OR:   y = a | b;
         OP_XOR:  y = a ^ b;
         default: y = '0;
      endcase
   end
endmodule

// File: rtl/iop_unit.sv
module iop_unit
   import iop_pkg::*;
#(
   parameter int DATA_W      = 64,
   parameter int WORD_W      = 32,
   parameter int LIT_W       = 8,
   parameter int SHIFT_SMALL = 2,
   parameter int SHIFT_LARGE = 3,
   parameter bit WORD_OPS    = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                issue_i,
   input  logic [3:0]          op_i,
   input  logic [2:0]          cond_i,
   input  logic                trap_en_i,
   input  logic                use_lit_i,
   input  logic [LIT_W-1:0]    lit_i,
   input  logic [DATA_W-1:0]   opa_i,
   input  logic [DATA_W-1:0]   opb_i,
   input  logic [DATA_W-1:0]   old_i,
   output logic [DATA_W-1:0]   res_o,
   output logic                res_vld_o,
   output logic                wr_en_o,
   output logic                ovf_o
);
   localparam int LIT_PAD = DATA_W - LIT_W;
   localparam int EXT_W   = DATA_W - WORD_W;

   generate
      if (WORD_W >= DATA_W) begin : g_bad_word
         $error("iop_unit: WORD_W must be below DATA_W");
      end
      if (LIT_W >= DATA_W) begin : g_bad_lit
         $error("iop_unit: LIT_W must be below DATA_W");
      end
      if (SHIFT_LARGE >= DATA_W || SHIFT_SMALL >= SHIFT_LARGE) begin : g_bad_shift
         $error("iop_unit: scale shifts out of range");
      end
   endgenerate

   iop_op_e           op;
   iop_cc_e           cc;
   logic [DATA_W-1:0] b_sel;
   logic [DATA_W-1:0] arith_y, logic_y;
   logic              arith_ovf, cmp_true, cc_ok;
   logic [DATA_W-1:0] res_d;
   logic              wr_d, ovf_d;

   assign op    = iop_op_e'(op_i);
   assign cc    = iop_cc_e'(cond_i);
   assign b_sel = use_lit_i ? {{LIT_PAD{1'b0}}, lit_i} : opb_i;

   iop_arith #(
      .DATA_W(DATA_W), .WORD_W(WORD_W), .SHIFT_SMALL(SHIFT_SMALL),
      .SHIFT_LARGE(SHIFT_LARGE), .WORD_OPS(WORD_OPS)
   ) u_arith (
      .op(op), .a(opa_i), .b(b_sel), .y(arith_y), .ovf(arith_ovf)
   );

   iop_cmp #(.DATA_W(DATA_W)) u_cmp (
      .op(op), .cc(cc), .a(opa_i), .b(b_sel),
      .cmp_true(cmp_true), .cc_ok(cc_ok)
   );

   iop_logic #(.DATA_W(DATA_W)) u_logic (
      .op(op), .a(opa_i), .b(b_sel), .y(logic_y)
   );

   always_comb begin
      wr_d  = issue_i;
      ovf_d = 1'b0;
      unique case (op)
         OP_ADD_D, OP_SUB_D, OP_ADD_W, OP_SUB_W,
         OP_SADD4, OP_SADD8, OP_SSUB4, OP_SSUB8: begin
            res_d = arith_y;
            ovf_d = issue_i & trap_en_i & arith_ovf;
         end
         OP_CEQ, OP_CLT, OP_CLE, OP_CULT:
            res_d = {{(DATA_W-1){1'b0}}, cmp_true};
         OP_AND, OP_OR, OP_XOR:
            res_d = logic_y;
         default: begin
            res_d = cc_ok ? b_sel : old_i;
            wr_d  = issue_i & cc_ok;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_o     <= '0;
         res_vld_o <= 1'b0;
         wr_en_o   <= 1'b0;
         ovf_o     <= 1'b0;
      end else begin
         res_vld_o <= issue_i;
         wr_en_o   <= wr_d;
         ovf_o     <= ovf_d;
         if (issue_i) res_o <= res_d;
      end
   end

   // R1
   issue_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      issue_i |=> res_vld_o);
   // R12
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !issue_i |=> (!res_vld_o && !wr_en_o && !ovf_o));
   // R4
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_i && !trap_en_i) |=> !ovf_o);
   // R5
   trap_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |-> (wr_en_o && res_vld_o));
   // R7
   scaled_no_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_i && op_i >= 4'd4 && op_i <= 4'd7) |=> !ovf_o);
   // R8
   cmp_bool_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_i && op_i >= 4'd8 && op_i <= 4'd11) |=> (res_o[DATA_W-1:1] == '0));
   // R6
   word_canon_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_i && (op_i == 4'd2 || op_i == 4'd3)) |=>
         (res_o[DATA_W-1:WORD_W] == {EXT_W{res_o[WORD_W-1]}}));
   // R10
   cmov_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_i && op_i == 4'd15 && !cc_ok) |=> (!wr_en_o && res_o == $past(old_i)));
endmodule

// File: tb/iop_unit_bench.sv
module iop_unit_bench;
   import iop_pkg::*;

   typedef struct {
      logic [63:0] res;
      logic        wr;
      logic        ovf;
      int          cyc;
      string       req;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        issue_i = 1'b0;
   logic [3:0]  op_i = '0;
   logic [2:0]  cond_i = '0;
   logic        trap_en_i = 1'b0;
   logic        use_lit_i = 1'b0;
   logic [7:0]  lit_i = '0;
   logic [63:0] opa_i = '0, opb_i = '0, old_i = '0;
   logic [63:0] res_o;
   logic        res_vld_o, wr_en_o, ovf_o;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 1'b0;
   exp_t q[$];

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   iop_unit u_iop_unit (
      .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .op_i(op_i),
      .cond_i(cond_i), .trap_en_i(trap_en_i), .use_lit_i(use_lit_i),
      .lit_i(lit_i), .opa_i(opa_i), .opb_i(opb_i), .old_i(old_i),
      .res_o(res_o), .res_vld_o(res_vld_o), .wr_en_o(wr_en_o), .ovf_o(ovf_o)
   );

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic exp_t model(input logic [3:0] op, input logic [2:0] cc,
         input logic te, input logic ul, input logic [7:0] lit,
         input logic [63:0] a, input logic [63:0] b, input logic [63:0] old);
      exp_t e;
      logic [63:0] bb, r, sa;
      logic [31:0] t;
      logic ov, c;
      bb = ul ? {56'b0, lit} : b;
      ov = 1'b0;
      e.wr = 1'b1;
      sa = (op == 4'd4 || op == 4'd6) ? (a << 2) : (a << 3);
      case (op)
         4'd0: begin r = a + bb; ov = (a[63] == bb[63]) && (r[63] != a[63]); end
         4'd1: begin r = a - bb; ov = (a[63] != bb[63]) && (r[63] != a[63]); end
         4'd2: begin t = a[31:0] + bb[31:0]; r = {{32{t[31]}}, t};
                     ov = (a[31] == bb[31]) && (t[31] != a[31]); end
         4'd3: begin t = a[31:0] - bb[31:0]; r = {{32{t[31]}}, t};
                     ov = (a[31] != bb[31]) && (t[31] != a[31]); end
         4'd4, 4'd5: r = sa + bb;
         4'd6, 4'd7: r = sa - bb;
         4'd8:  r = {63'b0, a == bb};
         4'd9:  r = {63'b0, $signed(a) < $signed(bb)};
         4'd10: r = {63'b0, $signed(a) <= $signed(bb)};
         4'd11: r = {63'b0, a < bb};
         4'd12: r = a & bb;
         4'd13: r = a | bb;
         4'd14: r = a ^ bb;
         default: begin
            case (cc)
               3'd0: c = (a == 0);
               3'd1: c = (a != 0);
               3'd2: c = a[63];
               3'd3: c = !a[63];
               3'd4: c = a[63] || (a == 0);
               3'd5: c = !a[63] && (a != 0);
               3'd6: c = a[0];
               default: c = !a[0];
            endcase
            r = c ? bb : old;
            e.wr = c;
         end
      endcase
      e.res = r;
      e.ovf = ov && te;
      return e;
   endfunction

   task automatic drive(input string req, input logic [3:0] op, input logic [2:0] cc,
         input logic te, input logic ul, input logic [7:0] lit,
         input logic [63:0] a, input logic [63:0] b, input logic [63:0] old);
      exp_t e;
      @(negedge clk);
      issue_i = 1'b1; op_i = op; cond_i = cc; trap_en_i = te;
      use_lit_i = ul; lit_i = lit; opa_i = a; opb_i = b; old_i = old;
      e = model(op, cc, te, ul, lit, a, b, old);
      e.cyc = cyc;
      e.req = req;
      q.push_back(e);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         issue_i = 1'b0;
         opa_i = 64'hDEAD_BEEF_0BAD_F00D;
      end
   endtask

   // monitor: pops expected items as results appear
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && !done) begin
            if (res_vld_o) begin
               if (q.size() == 0) begin
                  check(1'b0, "R1 unexpected valid", 64'd1, 64'd0);
               end else begin
                  exp_t e;
                  e = q.pop_front();
                  check(e.cyc + 1 == cyc, {"R1 latency ", e.req}, 64'(cyc), 64'(e.cyc + 1));
                  check(res_o == e.res, {e.req, " result"}, res_o, e.res);
                  check(wr_en_o == e.wr, {e.req, " wr_en"}, 64'(wr_en_o), 64'(e.wr));
                  check(ovf_o == e.ovf, {e.req, " trap"}, 64'(ovf_o), 64'(e.ovf));
               end
            end else begin
               check(!wr_en_o && !ovf_o, "R12 idle outputs", {62'b0, wr_en_o, ovf_o}, 64'd0);
               if (q.size() > 0 && q[0].cyc + 1 <= cyc)
                  check(1'b0, "R1 missing valid", 64'd0, 64'd1);
            end
         end
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++;
         checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   localparam logic [63:0] MAXP = 64'h7FFF_FFFF_FFFF_FFFF;
   localparam logic [63:0] MINN = 64'h8000_0000_0000_0000;
   localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

   initial begin
      repeat (3) @(negedge clk);
      // R11 outputs cleared in reset
      check(res_o == 0 && !res_vld_o && !wr_en_o && !ovf_o, "R11 in reset",
            res_o | {61'b0, res_vld_o, wr_en_o, ovf_o}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(res_o == 0 && !res_vld_o && !wr_en_o && !ovf_o, "R11 after reset",
            res_o | {61'b0, res_vld_o, wr_en_o, ovf_o}, 64'd0);
      // R3 plain add/sub
      drive("R3 add", 4'd0, 3'd0, 1'b1, 1'b0, 8'h00, 64'd5, 64'd7, 64'd0);
      drive("R3 sub wrap", 4'd1, 3'd0, 1'b1, 1'b0, 8'h00, 64'd3, 64'd10, 64'd0);
      // R4 overflow with and without enable
      drive("R4 add ovf trap", 4'd0, 3'd0, 1'b1, 1'b0, 8'h00, MAXP, 64'd1, 64'd0);
      drive("R4 add ovf quiet", 4'd0, 3'd0, 1'b0, 1'b0, 8'h00, MAXP, 64'd1, 64'd0);
      drive("R5 sub ovf trap", 4'd1, 3'd0, 1'b1, 1'b0, 8'h00, MINN, 64'd1, 64'd0);
      drive("R4 sub ovf quiet", 4'd1, 3'd0, 1'b0, 1'b0, 8'h00, MINN, 64'd1, 64'd0);
      drive("R4 neg add no ovf", 4'd0, 3'd0, 1'b1, 1'b0, 8'h00, ONES, ONES, 64'd0);
      idle(2);
      // R2 literal operand
      drive("R2 literal", 4'd0, 3'd0, 1'b0, 1'b1, 8'hFF, 64'd1, 64'h1234_0000_0000_0000, 64'd0);
      drive("R2 register", 4'd0, 3'd0, 1'b0, 1'b0, 8'hFF, 64'd1, 64'h1234_0000_0000_0000, 64'd0);
      // R6 32-bit ops
      drive("R6 add32 ovf", 4'd2, 3'd0, 1'b1, 1'b0, 8'h00, 64'h7FFF_FFFF, 64'd1, 64'd0);
      drive("R6 add32 high ignored", 4'd2, 3'd0, 1'b1, 1'b0, 8'h00,
            64'h1234_5678_0000_0001, 64'hFFFF_0000_0000_0002, 64'd0);
      drive("R6 sub32 neg", 4'd3, 3'd0, 1'b1, 1'b0, 8'h00, 64'd0, 64'd1, 64'd0);
      drive("R6 sub32 ovf", 4'd3, 3'd0, 1'b1, 1'b0, 8'h00, 64'h8000_0000, 64'd1, 64'd0);
      drive("R6 add32 64bit-ovf only", 4'd2, 3'd0, 1'b1, 1'b0, 8'h00, MAXP, 64'h0000_0000_7000_0000, 64'd0);
      // R7 scaled
      drive("R7 s4add", 4'd4, 3'd0, 1'b1, 1'b0, 8'h00, 64'd3, 64'd10, 64'd0);
      drive("R7 s8add", 4'd5, 3'd0, 1'b1, 1'b1, 8'h05, 64'd4, 64'd0, 64'd0);
      drive("R7 s4sub", 4'd6, 3'd0, 1'b1, 1'b0, 8'h00, 64'd1, 64'd9, 64'd0);
      drive("R7 s8sub", 4'd7, 3'd0, 1'b1, 1'b0, 8'h00, 64'd2, 64'd1, 64'd0);
      drive("R7 s8add no trap", 4'd5, 3'd0, 1'b1, 1'b0, 8'h00, 64'h1000_0000_0000_0000, MAXP, 64'd0);
      idle(1);
      // R8 compares
      drive("R8 eq true", 4'd8, 3'd0, 1'b0, 1'b0, 8'h00, 64'd42, 64'd42, 64'd7);
      drive("R8 eq false", 4'd8, 3'd0, 1'b0, 1'b0, 8'h00, 64'd42, 64'd43, 64'd7);
      drive("R8 lt signed", 4'd9, 3'd0, 1'b0, 1'b0, 8'h00, ONES, 64'd1, 64'd7);
      drive("R8 lt equal", 4'd9, 3'd0, 1'b0, 1'b0, 8'h00, 64'd5, 64'd5, 64'd7);
      drive("R8 le equal", 4'd10, 3'd0, 1'b0, 1'b0, 8'h00, 64'd5, 64'd5, 64'd7);
      drive("R8 le greater", 4'd10, 3'd0, 1'b0, 1'b0, 8'h00, 64'd6, 64'd5, 64'd7);
      drive("R8 ult", 4'd11, 3'd0, 1'b0, 1'b0, 8'h00, ONES, 64'd1, 64'd7);
      drive("R8 ult true", 4'd11, 3'd0, 1'b0, 1'b1, 8'h80, 64'd1, 64'd0, 64'd7);
      // R9 logical
      drive("R9 and", 4'd12, 3'd0, 1'b1, 1'b0, 8'h00, 64'hF0F0_1234_FFFF_0000, 64'h0FF0_FFFF_00FF_FFFF, 64'd0);
      drive("R9 or", 4'd13, 3'd0, 1'b1, 1'b0, 8'h00, 64'hF0F0_0000_0000_0001, 64'h0000_0000_0000_0100, 64'd0);
      drive("R9 xor", 4'd14, 3'd0, 1'b1, 1'b0, 8'h00, ONES, 64'h0123_4567_89AB_CDEF, 64'd0);
      idle(3);
      // R10 conditional move, every condition met and not met
      for (int c = 0; c < 8; c++) begin
         drive("R10 cmov zero", 4'd15, 3'(c), 1'b1, 1'b0, 8'h00, 64'd0, 64'hAAAA, 64'h5555);
         drive("R10 cmov neg", 4'd15, 3'(c), 1'b1, 1'b0, 8'h00, ONES, 64'hBBBB, 64'h6666);
         drive("R10 cmov pos even", 4'd15, 3'(c), 1'b1, 1'b0, 8'h00, 64'd2, 64'hCCCC, 64'h7777);
         drive("R10 cmov pos odd", 4'd15, 3'(c), 1'b1, 1'b1, 8'h3C, 64'd3, 64'hDDDD, 64'h8888);
      end
      idle(1);
      // R12 gaps between issues
      drive("R1 single", 4'd0, 3'd0, 1'b1, 1'b0, 8'h00, MAXP, 64'd1, 64'd0);
      idle(2);
      drive("R1 single2", 4'd13, 3'd0, 1'b0, 1'b0, 8'h00, 64'd1, 64'd2, 64'd0);
      idle(4);
      check(q.size() == 0, "R1 drained", 64'(q.size()), 64'd0);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule